// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps one private, direct-mapped, writeback cache coherent with its peers on a shared snooping bus. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. Processor loads and stores come in on a valid/ready request channel. Misses, upgrades and dirty evictions go out as bus requests. Transactions from other caches come in on a snoop port. Each line holds a single data word, so a line is identified by an index and a tag.

A read miss installs the line in Exclusive when no other cache drives the wired shared line during the fill. A later store to that line becomes Modified without using the bus. When a snooped read finds a valid copy, this controller drives the shared line. It places its data on the flush port when it holds the line dirty or alone, or when it is in Shared and the system has named this cache as the supplier. When a snooped read-exclusive finds a valid copy, the line becomes Invalid. A dirty or sole copy is flushed first.

Back-pressure rules: a processor request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. Ready is low while a request is in progress and in any cycle that carries a snoop, so snoops always win. Once `bus_req_valid` rises, the command, address and data stay fixed until `bus_req_ready` is seen. The one exception is a pending writeback whose line a snoop has already flushed or invalidated. That request is withdrawn. The response, the fill and the flush are single-cycle pulses and cannot be stalled.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: A read miss issues a bus command of 1 (read). The filled line becomes Exclusive if `bus_fill_shared` is low in the fill cycle, and Shared if it is high. The response returns the fill data.
- R2: A store that hits an Exclusive line makes it Modified and issues no bus command.
- R3: A store that hits a Shared line, or misses, issues bus command 2 (read-exclusive). The line ends Modified and holds the store data. Fill data is discarded for stores.
- R4: Loads that hit Shared, Exclusive or Modified lines, and stores that hit Modified lines, issue no bus command. A load returns the stored word.
- R5: A snooped read (`snp_excl`=0) that hits a Modified or Exclusive line pulses `flush_valid` with the line data in the same cycle, and the line becomes Shared.
- R6: A snooped read-exclusive (`snp_excl`=1) that hits a valid line makes it Invalid. Modified and Exclusive copies flush their data in that cycle, and `snp_shared` stays low.
- R7: `snp_shared` is high in exactly those cycles where a snooped read hits a valid line.
- R8: A Shared line flushes on a snoop only when `snp_supplier` is high. Otherwise it raises no flush.
- R9: Replacing a Modified line first issues bus command 3 (writeback) with the victim's data and address, and then the fill request. Replacing an Exclusive or Shared line issues only the fill request.
- R10: A snoop to an Invalid line, or to an index holding a different tag, produces no shared signal, no flush and no state change.
- R11: `cpu_req_ready` is low during any snoop cycle and while a request is in progress. A stalled bus request holds its command and address. Each accepted request yields exactly one single-cycle response.
- R12: After reset every line is Invalid. The first access to any address therefore misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address, index in low bits, tag above |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Load data, or store data for a store |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_ready | input | 1 | Bus grants the pending request |
| bus_req_cmd | output | 2 | 1 read, 2 read-exclusive, 3 writeback |
| bus_req_addr | output | ADDR_W | Request address |
| bus_req_wdata | output | DATA_W | Writeback data |
| bus_fill_valid | input | 1 | Fill data present for the granted read |
| bus_fill_data | input | DATA_W | Fill data |
| bus_fill_shared | input | 1 | Wired shared line sampled with the fill |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_excl | input | 1 | 1 = read-exclusive, 0 = read |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supplier | input | 1 | This cache is the designated supplier among sharers |
| snp_shared | output | 1 | Drive of the wired shared line |
| flush_valid | output | 1 | Line data is being supplied on the bus |
| flush_data | output | DATA_W | Supplied line data |

## Verification
The main function is driven with access sequences that move the same lines through every state. An unshared fill followed by a store tells a silent Exclusive upgrade apart from a Shared upgrade that needs read-exclusive. A shared fill followed by a non-supplier snoop tells Shared apart from Exclusive, because only Exclusive flushes. Conflicting tags on one index separate a dirty eviction with writeback from a silent clean one. Snoops with a matching index but another tag, or to invalid lines, show that misses are ignored, and a stalled writeback shows that the bus request holds.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_RDX  = 2'd2,
    BUS_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_WB,
    F_REQ,
    F_FILL,
    F_RESP
  } fsm_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 6,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor-side view
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  // snoop-side view
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  // processor-side write (wins over snoop)
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  line_st_e          cw_state,
  input  logic [TAG_W-1:0]  cw_tag,
  input  logic              cw_data_en,
  input  logic [DATA_W-1:0] cw_data,
  // snoop-side state write
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_e          sw_state
);
  line_st_e          st_q  [NUM_LINES];
  logic [TAG_W-1:0]  tag_q [NUM_LINES];
  logic [DATA_W-1:0] dat_q [NUM_LINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!rst_n) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end else if (cw_en && cw_idx == IDX_W'(i)) begin
        st_q[i]  <= cw_state;
        tag_q[i] <= cw_tag;
        if (cw_data_en) dat_q[i] <= cw_data;
      end else if (sw_en && sw_idx == IDX_W'(i)) begin
        st_q[i] <= sw_state;
      end
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = dat_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = dat_q[b_idx];

  // A snoop transition not overridden by the processor port lands in the array.
  assert_snoop_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !(cw_en && cw_idx == sw_idx)) |=> (st_q[$past(sw_idx)] == $past(sw_state)));
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snp_valid,
  input  logic     snp_excl,
  input  logic     tag_match,
  input  line_st_e line_state,
  input  logic     supplier,
  output logic     shared_o,
  output logic     flush_o,
  output logic     st_we,
  output line_st_e st_next
);
  logic hit;

  assign hit      = snp_valid && tag_match && (line_state != ST_I);
  assign shared_o = hit && !snp_excl;
  assign flush_o  = hit && ((line_state == ST_M) || (line_state == ST_E) ||
                            ((line_state == ST_S) && supplier));
  assign st_we    = hit;
  assign st_next  = snp_excl ? ST_I : ST_S;

  // A sharer that is not the supplier stays silent.
  assert_sharer_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && line_state == ST_S && !supplier) |-> !flush_o);

  // Dirty data is never lost on a snoop hit.
  assert_dirty_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && tag_match && line_state == ST_M) |-> flush_o);

  // Read-exclusive never raises the shared line.
  assert_rdx_no_share_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_excl) |-> !shared_o);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              bus_fill_shared,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_supplier,
  output logic              snp_shared,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_e              fsm_q, fsm_d;
  logic              lat_write;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  bus_cmd_e          lat_cmd;
  logic [DATA_W-1:0] rsp_q, rsp_d;
  logic              rsp_load;

  logic [IDX_W-1:0]  req_idx, lat_idx, snp_idx, a_idx;
  logic [TAG_W-1:0]  req_tag, lat_tag, snp_tag, cur_tag;
  line_st_e          a_state, b_state;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  logic              cw_en, cw_data_en;
  line_st_e          cw_state;
  logic [TAG_W-1:0]  cw_tag;
  logic [DATA_W-1:0] cw_data;
  logic              sw_en;
  line_st_e          sw_state;

  logic              accept, a_hit, victim_m;
  bus_cmd_e          cmd_d;

  assign req_idx = cpu_req_addr[IDX_W-1:0];
  assign req_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign lat_idx = lat_addr[IDX_W-1:0];
  assign lat_tag = lat_addr[ADDR_W-1 -: TAG_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];

  assign a_idx   = (fsm_q == F_IDLE) ? req_idx : lat_idx;
  assign cur_tag = (fsm_q == F_IDLE) ? req_tag : lat_tag;
  assign a_hit   = (a_state != ST_I) && (a_tag == cur_tag);
  assign victim_m = (a_state == ST_M) && (a_tag != lat_tag);

  assign cpu_req_ready = (fsm_q == F_IDLE) && !snp_valid;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign cpu_rsp_rdata = rsp_q;

  mesi_line_store #(
    .NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_idx(snp_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .cw_en(cw_en), .cw_idx(a_idx), .cw_state(cw_state), .cw_tag(cw_tag),
    .cw_data_en(cw_data_en), .cw_data(cw_data),
    .sw_en(sw_en), .sw_idx(snp_idx), .sw_state(sw_state)
  );

  mesi_snoop_unit snoop_i (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_excl(snp_excl),
    .tag_match(b_tag == snp_tag), .line_state(b_state),
    .supplier(snp_supplier),
    .shared_o(snp_shared), .flush_o(flush_valid),
    .st_we(sw_en), .st_next(sw_state)
  );

  assign flush_data = b_data;

  always_comb begin
    fsm_d         = fsm_q;
    cw_en         = 1'b0;
    cw_state      = ST_I;
    cw_tag        = a_tag;
    cw_data_en    = 1'b0;
    cw_data       = lat_wdata;
    rsp_load      = 1'b0;
    rsp_d         = a_data;
    bus_req_valid = 1'b0;
    bus_req_cmd   = BUS_NONE;
    bus_req_addr  = lat_addr;
    bus_req_wdata = a_data;
    cpu_rsp_valid = 1'b0;
    cmd_d         = cpu_req_write ? BUS_RDX : BUS_RD;
    unique case (fsm_q)
      F_IDLE: begin
        if (accept) begin
          if (a_hit && !cpu_req_write) begin
            rsp_load = 1'b1;
            fsm_d    = F_RESP;
          end else if (a_hit && (a_state == ST_M || a_state == ST_E)) begin
            cw_en      = 1'b1;
            cw_state   = ST_M;
            cw_tag     = req_tag;
            cw_data_en = 1'b1;
            cw_data    = cpu_req_wdata;
            rsp_load   = 1'b1;
            rsp_d      = cpu_req_wdata;
            fsm_d      = F_RESP;
          end else if (a_hit) begin
            fsm_d = F_REQ;
          end else if (a_state == ST_M) begin
            fsm_d = F_WB;
          end else begin
            fsm_d = F_REQ;
          end
        end
      end
      F_WB: begin
        if (victim_m) begin
          bus_req_valid = 1'b1;
          bus_req_cmd   = BUS_WB;
          bus_req_addr  = {a_tag, lat_idx};
          if (bus_req_ready) begin
            cw_en    = 1'b1;
            cw_state = ST_I;
            fsm_d    = F_REQ;
          end
        end else begin
          fsm_d = F_REQ;
        end
      end
      F_REQ: begin
        bus_req_valid = 1'b1;
        bus_req_cmd   = lat_cmd;
        if (bus_req_ready) fsm_d = F_FILL;
      end
      F_FILL: begin
        if (bus_fill_valid) begin
          cw_en      = 1'b1;
          cw_tag     = lat_tag;
          cw_data_en = 1'b1;
          cw_data    = lat_write ? lat_wdata : bus_fill_data;
          cw_state   = lat_write ? ST_M : (bus_fill_shared ? ST_S : ST_E);
          rsp_load   = 1'b1;
          rsp_d      = cw_data;
          fsm_d      = F_RESP;
        end
      end
      F_RESP: begin
        cpu_rsp_valid = 1'b1;
        fsm_d         = F_IDLE;
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q     <= F_IDLE;
      lat_write <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_cmd   <= BUS_RD;
      rsp_q     <= '0;
    end else begin
      fsm_q <= fsm_d;
      if (accept) begin
        lat_write <= cpu_req_write;
        lat_addr  <= cpu_req_addr;
        lat_wdata <= cpu_req_wdata;
        lat_cmd   <= cmd_d;
      end
      if (rsp_load) rsp_q <= rsp_d;
    end
  end

  // A stalled bus request keeps its command and address while no snoop intervenes.
  assert_bus_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready && !snp_valid) |=>
      (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr)));

  // Responses are single-cycle pulses.
  assert_single_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  // A fill completes the request on the next cycle.
  assert_fill_to_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_FILL && bus_fill_valid) |=> cpu_rsp_valid);

  // A store hitting Exclusive completes without the bus.
  assert_silent_upgrade_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_req_write && a_hit && a_state == ST_E) |=>
      (cpu_rsp_valid && !bus_req_valid));
endmodule

// File: tb/mesi_snoop_ctrl_tb_top.sv
module mesi_snoop_ctrl_tb_top;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SR = 2'd2, OP_SX = 2'd3;
  localparam logic [1:0] C_NO = 2'd0, C_RD = 2'd1, C_RDX = 2'd2, C_WB = 2'd3;
  localparam int NV = 21;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [15:0] data;   // store data, or fill data for loads
    logic        shin;
    logic        sup;
    logic [1:0]  e1;
    logic [1:0]  e2;
    logic [15:0] ewb;
    logic [15:0] erd;    // response data, or flush data for snoops
    logic        esh;
    logic        efl;
  } vec_t;

  // A = 8'h10 (index 0), B = 8'h20 (index 0), C = 8'h05 (index 1)
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 8'h10, 16'h1111, 1'b0, 1'b0, C_RD,  C_NO, 16'h0,    16'h1111, 1'b0, 1'b0}, // R1 -> E
    '{OP_WR, 8'h10, 16'h2222, 1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'h2222, 1'b0, 1'b0}, // R2
    '{OP_SR, 8'h10, 16'h0,    1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'h2222, 1'b1, 1'b1}, // R5 M->S
    '{OP_RD, 8'h10, 16'h0,    1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'h2222, 1'b0, 1'b0}, // R4 S hit
    '{OP_SR, 8'h10, 16'h0,    1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'h0,    1'b1, 1'b0}, // R8 no sup
    '{OP_SR, 8'h10, 16'h0,    1'b0, 1'b1, C_NO,  C_NO, 16'h0,    16'h2222, 1'b1, 1'b1}, // R8 sup
    '{OP_WR, 8'h10, 16'h3333, 1'b0, 1'b0, C_RDX, C_NO, 16'h0,    16'h3333, 1'b0, 1'b0}, // R3 S->M
    '{OP_RD, 8'h20, 16'h4444, 1'b1, 1'b0, C_WB,  C_RD, 16'h3333, 16'h4444, 1'b0, 1'b0}, // R9, R1 -> S
    '{OP_SX, 8'h20, 16'h0,    1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'h0,    1'b0, 1'b0}, // R6 S->I
    '{OP_RD, 8'h20, 16'h5555, 1'b0, 1'b0, C_RD,  C_NO, 16'h0,    16'h5555, 1'b0, 1'b0}, // R6 miss proves I
    '{OP_SR, 8'h05, 16'h0,    1'b0, 1'b1, C_NO,  C_NO, 16'h0,    16'h0,    1'b0, 1'b0}, // R10 invalid
    '{OP_SR, 8'h10, 16'h0,    1'b0, 1'b1, C_NO,  C_NO, 16'h0,    16'h0,    1'b0, 1'b0}, // R10 tag miss
    '{OP_SR, 8'h20, 16'h0,    1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'h5555, 1'b1, 1'b1}, // R5 E->S
    '{OP_RD, 8'h10, 16'h6666, 1'b0, 1'b0, C_RD,  C_NO, 16'h0,    16'h6666, 1'b0, 1'b0}, // R9 silent S evict
    '{OP_SX, 8'h10, 16'h0,    1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'h6666, 1'b0, 1'b1}, // R6 E flush
    '{OP_WR, 8'h05, 16'h7777, 1'b0, 1'b0, C_RDX, C_NO, 16'h0,    16'h7777, 1'b0, 1'b0}, // R3 I->M
    '{OP_SX, 8'h05, 16'h0,    1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'h7777, 1'b0, 1'b1}, // R6 M flush
    '{OP_RD, 8'h05, 16'h8888, 1'b0, 1'b0, C_RD,  C_NO, 16'h0,    16'h8888, 1'b0, 1'b0}, // R1 -> E
    '{OP_WR, 8'h05, 16'h9999, 1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'h9999, 1'b0, 1'b0}, // R2
    '{OP_RD, 8'h05, 16'h0,    1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'h9999, 1'b0, 1'b0}, // R4 M hit
    '{OP_WR, 8'h05, 16'hABCD, 1'b0, 1'b0, C_NO,  C_NO, 16'h0,    16'hABCD, 1'b0, 1'b0}  // R4 M write
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [7:0]  cpu_req_addr = '0;
  logic [15:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [15:0] cpu_rsp_rdata;
  logic        bus_req_valid;
  logic        bus_req_ready = 1'b0;
  logic [1:0]  bus_req_cmd;
  logic [7:0]  bus_req_addr;
  logic [15:0] bus_req_wdata;
  logic        bus_fill_valid = 1'b0, bus_fill_shared = 1'b0;
  logic [15:0] bus_fill_data = '0;
  logic        snp_valid = 1'b0, snp_excl = 1'b0, snp_supplier = 1'b0;
  logic [7:0]  snp_addr = '0;
  logic        snp_shared, flush_valid;
  logic [15:0] flush_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [1:0]  g_c1, g_c2;
  logic [15:0] g_wb, g_rd, g_fd;
  logic [7:0]  g_wba;
  logic        g_sh, g_fl, g_rdy;

  always #4 clk = ~clk;

  mesi_snoop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .bus_req_valid(bus_req_valid),
    .bus_req_ready(bus_req_ready), .bus_req_cmd(bus_req_cmd),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_fill_valid(bus_fill_valid), .bus_fill_data(bus_fill_data),
    .bus_fill_shared(bus_fill_shared), .snp_valid(snp_valid),
    .snp_excl(snp_excl), .snp_addr(snp_addr), .snp_supplier(snp_supplier),
    .snp_shared(snp_shared), .flush_valid(flush_valid), .flush_data(flush_data)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Runs one processor access, acting as the bus; stall delays each grant.
  task automatic run_cpu(input logic wr, input logic [7:0] ad, input logic [15:0] dat,
                         input logic sh, input int stall);
    logic accepted = 1'b0, done = 1'b0, fill_next = 1'b0;
    int   waited = 0, n = 0;
    g_c1 = C_NO; g_c2 = C_NO; g_wb = '0; g_wba = '0; g_rd = '0;
    @(posedge clk); #1;
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = ad; cpu_req_wdata = dat;
    while (!done) begin
      #2;
      if (cpu_req_valid && cpu_req_ready) accepted = 1'b1;
      if (bus_req_valid) begin
        if (waited < stall) begin
          waited++;
          chk("R11 stalled request held, ready low", {bus_req_valid, cpu_req_ready}, 2'b10);
        end else begin
          bus_req_ready = 1'b1;
          if (n == 0) begin
            g_c1 = bus_req_cmd; g_wb = bus_req_wdata; g_wba = bus_req_addr;
          end else g_c2 = bus_req_cmd;
          n++;
          if (bus_req_cmd != C_WB) fill_next = 1'b1;
          waited = 0;
        end
      end
      if (cpu_rsp_valid) begin
        g_rd = cpu_rsp_rdata;
        done = 1'b1;
      end
      @(posedge clk); #1;
      bus_req_ready = 1'b0;
      bus_fill_valid = 1'b0;
      if (accepted) cpu_req_valid = 1'b0;
      if (fill_next) begin
        bus_fill_valid  = 1'b1;
        bus_fill_data   = wr ? 16'hDEAD : dat;
        bus_fill_shared = sh;
        fill_next = 1'b0;
      end
    end
  endtask

  task automatic run_snp(input logic ex, input logic [7:0] ad, input logic sup);
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_excl = ex; snp_addr = ad; snp_supplier = sup;
    #2;
    g_sh = snp_shared; g_fl = flush_valid; g_fd = flush_data; g_rdy = cpu_req_ready;
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  initial begin
    do_reset();
    // R12: reset state at the ports.
    #2;
    chk("R12 idle after reset", {cpu_req_ready, bus_req_valid, cpu_rsp_valid}, 3'b100);
    run_snp(1'b0, 8'h10, 1'b1);
    chk("R12 empty cache ignores snoop", {g_sh, g_fl}, 2'b00);
    chk("R11 ready low during snoop", g_rdy, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == OP_RD || VECS[i].op == OP_WR) begin
        run_cpu(VECS[i].op == OP_WR, VECS[i].addr, VECS[i].data, VECS[i].shin, 0);
        chk($sformatf("R1-R4/R9 vec %0d first bus cmd", i), g_c1, VECS[i].e1);
        chk($sformatf("R9 vec %0d second bus cmd", i), g_c2, VECS[i].e2);
        chk($sformatf("R4 vec %0d response data", i), g_rd, VECS[i].erd);
        if (VECS[i].e1 == C_WB) begin
          chk($sformatf("R9 vec %0d writeback data", i), g_wb, VECS[i].ewb);
          chk($sformatf("R9 vec %0d writeback addr", i), g_wba, 8'h10);
        end
      end else begin
        run_snp(VECS[i].op == OP_SX, VECS[i].addr, VECS[i].sup);
        chk($sformatf("R7 vec %0d shared signal", i), g_sh, VECS[i].esh);
        chk($sformatf("R5/R6/R8 vec %0d flush", i), g_fl, VECS[i].efl);
        chk($sformatf("R11 vec %0d ready low during snoop", i), g_rdy, 1'b0);
        if (VECS[i].efl)
          chk($sformatf("R5 vec %0d flush data", i), g_fd, VECS[i].erd);
      end
    end

    // R9 with a stalled grant: C (index 1) is Modified with ABCD; 8'h45 evicts it.
    run_cpu(1'b0, 8'h45, 16'h1234, 1'b0, 3);
    chk("R9 stalled eviction writeback first", g_c1, C_WB);
    chk("R9 stalled eviction writeback data", g_wb, 16'hABCD);
    chk("R9 stalled eviction writeback addr", g_wba, 8'h05);
    chk("R1 fill after writeback", g_c2, C_RD);
    chk("R1 response data after stall", g_rd, 16'h1234);

    // R10: matching index, other tag, must leave 8'h45 Exclusive (flushes on read).
    run_snp(1'b1, 8'h05, 1'b1);
    chk("R10 tag mismatch no flush", {g_sh, g_fl}, 2'b00);
    run_snp(1'b0, 8'h45, 1'b0);
    chk("R10 line still Exclusive", {g_sh, g_fl}, 2'b11);
    chk("R5 flush data from Exclusive", g_fd, 16'h1234);

    // R12: a mid-run reset drops all lines.
    do_reset();
    run_snp(1'b0, 8'h45, 1'b1);
    chk("R12 reset clears lines", {g_sh, g_fl}, 2'b00);
    run_cpu(1'b0, 8'h45, 16'h4321, 1'b0, 0);
    chk("R12 first access misses", g_c1, C_RD);

    report();
  end
endmodule